// File: doc/BRIEF.md
# Peripheral Power and Reset Sequencer

This block holds a set of peripheral modules in one of four clock/reset states and moves them between states on software command. Software writes a wanted state into each module's control register, then writes a start command. Every module whose wanted state differs from its present state is sequenced on its own. When the change would stop the module's clock or put it back into reset, the sequencer first raises an idle request and waits for the module's idle acknowledge. Only then does it change the clock enable and reset outputs, and it drops the request one cycle later. Transitions that only start the clock or release reset apply at once and raise no request.

A global busy flag stays set from the start command until every module involved has finished. If a module never acknowledges, busy stays set for good. A force flag in the module's control register lets the sequencer go ahead without the acknowledge. The flag is read live, so setting it while a module waits frees that module.

Acknowledge inputs pass through a synchronizer. All outputs, including read data, are registered. Read data appears on the cycle after the read strobe.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset every module is in state 1, with its clock enable high, its reset output high and its idle request low, and the busy flag is clear.
- R2: The state code sets the outputs. Bit 0 of the state is the clock enable. The module reset is asserted while bit 1 is 0. Code 0 means clock off and in reset, 1 means clock on and in reset, 2 means clock off and out of reset, 3 means fully enabled.
- R3: A write with bit 0 set to the command register at offset 0x120 starts a transition. Each module whose wanted state (bits 1:0 of its control register at 0xA00 + 4·i) differs from its present state moves to the wanted state. All other modules keep their state.
- R4: Bit 0 of the status register at 0x128 reads 1 from the command write until every module in the transition has reached its new state. It then reads 0.
- R5: A change that clears the clock enable or asserts reset first raises the module's idle request. The clock enable and reset outputs hold their values until the synchronized acknowledge is seen. Without an acknowledge the request and the busy flag stay set.
- R6: A change that neither stops the clock nor asserts reset never raises the idle request.
- R7: Bit 31 of a module's control register is a force flag. While it is set, a waiting module completes its transition without an acknowledge, including when the flag is set during the wait.
- R8: A start command written while busy is set has no effect on any module.
- R9: The module status register at 0x800 + 4·i returns the present state in bits 1:0 and the synchronized acknowledge level in bit 16.
- R10: The idle request falls after the outputs have changed, and it is low once the transition is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data valid next cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| idle_req | output | N_MOD | Per-module idle request |
| idle_ack | input | N_MOD | Per-module idle acknowledge (asynchronous) |
| mod_clk_en | output | N_MOD | Per-module clock enable |
| mod_rst | output | N_MOD | Per-module reset, active high |

## Verification
The hardest case is a module that never acknowledges. The bench checks that busy and the request stay high while that module's clock and reset outputs stay unchanged. A design that applied the change early, or cleared busy on a timer, would be caught there. The bench also checks that a later force write lets the module finish. A start command sent while that module hangs must not move a second module whose wanted state has changed; a design that re-armed on that command would move it. The bench watches the request line throughout a pure power-up, which must raise no request, and checks that the request drops after the outputs settle. The four state codes are checked against the clock and reset pins.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  // register map (byte offsets)
  localparam int CMD_OFF  = 'h120;
  localparam int STAT_OFF = 'h128;
  localparam int MST_BASE = 'h800;
  localparam int CTL_BASE = 'hA00;

  // bit positions
  localparam int ACK_BIT  = 16;

  // reset state: clock on, held in reset
  localparam logic [1:0] ST_SYNCRST = 2'd1;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_REQ,
    SQ_APPLY,
    SQ_DROP
  } seq_t;

  // a change needs the idle handshake if it stops the clock or asserts reset
  function automatic logic need_ack(input logic [1:0] cur, input logic [1:0] nxt);
    return (cur[0] & ~nxt[0]) | (cur[1] & ~nxt[1]);
  endfunction

endpackage

// File: rtl/pwr_ack_sync.sv
module pwr_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/pwr_mod_seq.sv
module pwr_mod_seq
  import pwr_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] tgt,
  input  logic       force_en,
  input  logic       ack_raw,
  output logic [1:0] cur,
  output logic       ack_lvl,
  output logic       idle_req,
  output logic       clk_en,
  output logic       mod_rst,
  output logic       active
);

  seq_t       st;
  logic [1:0] cur_q, tgt_q;
  logic       req_q, clk_en_q, rst_q;
  logic       ack_s;

  pwr_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ack_raw),
    .q   (ack_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      cur_q    <= ST_SYNCRST;
      tgt_q    <= ST_SYNCRST;
      req_q    <= 1'b0;
      clk_en_q <= ST_SYNCRST[0];
      rst_q    <= ~ST_SYNCRST[1];
    end else begin
      case (st)
        SQ_IDLE: begin
          if (start && (tgt != cur_q)) begin
            tgt_q <= tgt;
            if (need_ack(cur_q, tgt)) begin
              req_q <= 1'b1;
              st    <= SQ_REQ;
            end else begin
              st    <= SQ_APPLY;
            end
          end
        end
        SQ_REQ: begin
          if (ack_s || force_en) st <= SQ_APPLY;
        end
        SQ_APPLY: begin
          cur_q    <= tgt_q;
          clk_en_q <= tgt_q[0];
          rst_q    <= ~tgt_q[1];
          st       <= SQ_DROP;
        end
        default: begin
          req_q <= 1'b0;
          st    <= SQ_IDLE;
        end
      endcase
    end
  end

  assign cur      = cur_q;
  assign ack_lvl  = ack_s;
  assign idle_req = req_q;
  assign clk_en   = clk_en_q;
  assign mod_rst  = rst_q;
  assign active   = (st != SQ_IDLE);

  // R5: outputs frozen while waiting without acknowledge or force
  assert_hold_wait_R5: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_REQ && !ack_s && !force_en) |=> ($stable(clk_en_q) && $stable(rst_q)));

  // R5: clock stops only with the request raised
  assert_stop_under_req_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_en_q) |-> req_q);

  // R5: reset asserts only with the request raised
  assert_rst_under_req_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_q) |-> req_q);

  // R6: power-up style changes never raise a request
  assert_no_req_R6: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_IDLE && start && tgt != cur_q && !need_ack(cur_q, tgt)) |=> !req_q);

  // R10: the request is low whenever the sequencer rests
  assert_req_low_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_IDLE) |-> !req_q);

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int N_MOD       = 4,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_MOD-1:0]  idle_req,
  input  logic [N_MOD-1:0]  idle_ack,
  output logic [N_MOD-1:0]  mod_clk_en,
  output logic [N_MOD-1:0]  mod_rst
);

  localparam int IDX_W     = (N_MOD > 1) ? $clog2(N_MOD) : 1;
  localparam int FORCE_BIT = DATA_W - 1;
  localparam int SPAN      = 4 * N_MOD;

  logic [1:0]       ctl_next [N_MOD];
  logic [N_MOD-1:0] ctl_force;
  logic [1:0]       cur      [N_MOD];
  logic [N_MOD-1:0] ack_lvl, active;
  logic             busy_q, go_wr, start;

  // address decode
  logic [ADDR_W-1:0] ctl_off, mst_off;
  logic              ctl_hit, mst_hit;
  logic [IDX_W-1:0]  ctl_idx, mst_idx;

  always_comb begin
    ctl_off = bus_addr - ADDR_W'(CTL_BASE);
    mst_off = bus_addr - ADDR_W'(MST_BASE);
    ctl_hit = (bus_addr >= ADDR_W'(CTL_BASE)) && (ctl_off < ADDR_W'(SPAN)) &&
              (bus_addr[1:0] == 2'b00);
    mst_hit = (bus_addr >= ADDR_W'(MST_BASE)) && (mst_off < ADDR_W'(SPAN)) &&
              (bus_addr[1:0] == 2'b00);
    ctl_idx = ctl_off[IDX_W+1:2];
    mst_idx = mst_off[IDX_W+1:2];
  end

  assign go_wr = bus_wr && (bus_addr == ADDR_W'(CMD_OFF)) && bus_wdata[0];
  assign start = go_wr && !busy_q;

  // control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_MOD; i++) ctl_next[i] <= ST_SYNCRST;
      ctl_force <= '0;
    end else if (bus_wr && ctl_hit) begin
      ctl_next[ctl_idx]  <= bus_wdata[1:0];
      ctl_force[ctl_idx] <= bus_wdata[FORCE_BIT];
    end
  end

  // busy flag
  always_ff @(posedge clk) begin
    if (rst)                     busy_q <= 1'b0;
    else if (start)              busy_q <= 1'b1;
    else if (busy_q && !(|active)) busy_q <= 1'b0;
  end

  // per-module sequencers
  for (genvar g = 0; g < N_MOD; g++) begin : g_mod
    pwr_mod_seq #(.SYNC_STAGES(SYNC_STAGES)) u_seq (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .tgt      (ctl_next[g]),
      .force_en (ctl_force[g]),
      .ack_raw  (idle_ack[g]),
      .cur      (cur[g]),
      .ack_lvl  (ack_lvl[g]),
      .idle_req (idle_req[g]),
      .clk_en   (mod_clk_en[g]),
      .mod_rst  (mod_rst[g]),
      .active   (active[g])
    );
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (bus_addr == ADDR_W'(STAT_OFF)) begin
        bus_rdata[0] <= busy_q;
      end else if (ctl_hit) begin
        bus_rdata[1:0]       <= ctl_next[ctl_idx];
        bus_rdata[FORCE_BIT] <= ctl_force[ctl_idx];
      end else if (mst_hit) begin
        bus_rdata[1:0]     <= cur[mst_idx];
        bus_rdata[ACK_BIT] <= ack_lvl[mst_idx];
      end
    end
  end

  // R4: busy holds while any module is still moving
  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && |active) |=> busy_q);

  // R4: a start command raises busy
  assert_busy_rise_R4: assert property (@(posedge clk) disable iff (rst)
    go_wr |=> busy_q);

  // R8: a command during busy starts nothing in idle modules
  assert_go_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (go_wr && busy_q && !(|active)) |=> !(|active));

endmodule

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;

  localparam int N   = 4;
  localparam int AW  = 12;
  localparam int DW  = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [N-1:0]  idle_req, idle_ack, mod_clk_en, mod_rst;
  logic [N-1:0]  ack_en = '0, ack_hold = '0;
  logic [N-1:0]  req_seen = '0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  assign idle_ack = ack_hold | (idle_req & ack_en);

  always @(posedge clk) req_seen <= req_seen | idle_req;

  pwr_seq_ctrl #(.N_MOD(N), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .idle_req(idle_req), .idle_ack(idle_ack),
    .mod_clk_en(mod_clk_en), .mod_rst(mod_rst)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_addr  = AW'(addr);
    bus_wdata = data;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input int addr, output logic [31:0] data);
    @(negedge clk);
    bus_addr = AW'(addr);
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
    data     = bus_rdata;
  endtask

  task automatic go();
    bus_write('h120, 32'h1);
  endtask

  task automatic wait_idle(input string tag, input int limit);
    logic [31:0] d;
    bit done = 0;
    for (int k = 0; k < limit && !done; k++) begin
      bus_read('h128, d);
      if (d[0] == 1'b0) done = 1;
    end
    check(tag, 32'(done), 32'd1);
  endtask

  task automatic mod_state(input int i, output logic [31:0] d);
    bus_read('h800 + 4 * i, d);
  endtask

  // R1: reset state
  task automatic t_reset();
    logic [31:0] d;
    check("R1 clk_en", 32'(mod_clk_en), 32'hF);
    check("R1 mod_rst", 32'(mod_rst), 32'hF);
    check("R1 idle_req", 32'(idle_req), 32'h0);
    bus_read('h128, d);
    check("R1 busy", d, 32'h0);
    for (int i = 0; i < N; i++) begin
      mod_state(i, d);
      check("R1 cur state", d & 32'h3, 32'h1);
    end
  endtask

  // R3/R4/R6/R2: power up modules 0 and 1
  task automatic t_power_up();
    logic [31:0] d;
    req_seen = '0;
    bus_write('hA00, 32'h3);
    bus_write('hA04, 32'h3);
    go();
    bus_read('h128, d);
    check("R4 busy after go", d & 32'h1, 32'h1);
    wait_idle("R4 busy clears", 20);
    check("R6 no request on power up", 32'(req_seen), 32'h0);
    mod_state(0, d); check("R3 mod0 moved", d & 32'h3, 32'h3);
    mod_state(1, d); check("R3 mod1 moved", d & 32'h3, 32'h3);
    mod_state(2, d); check("R3 mod2 untouched", d & 32'h3, 32'h1);
    check("R2 clk_en code3/1", 32'(mod_clk_en), 32'hF);
    check("R2 mod_rst code3/1", 32'(mod_rst), 32'hC);
  endtask

  // R5/R10/R2: module 1 to state 0 with a late acknowledge
  task automatic t_handshake();
    logic [31:0] d;
    bus_write('hA04, 32'h0);
    go();
    repeat (20) @(negedge clk);
    check("R5 request raised", 32'(idle_req[1]), 32'h1);
    check("R5 clock held", 32'(mod_clk_en[1]), 32'h1);
    check("R5 reset held", 32'(mod_rst[1]), 32'h0);
    bus_read('h128, d);
    check("R5 busy while waiting", d & 32'h1, 32'h1);
    ack_en[1] = 1'b1;
    wait_idle("R5 completes after ack", 20);
    check("R10 request dropped", 32'(idle_req[1]), 32'h0);
    check("R2 code0 clk_en", 32'(mod_clk_en[1]), 32'h0);
    check("R2 code0 mod_rst", 32'(mod_rst[1]), 32'h1);
    mod_state(1, d); check("R3 mod1 state 0", d & 32'h3, 32'h0);
  endtask

  // R2/R5: module 3 to state 2 (stops clock, releases reset)
  task automatic t_code2();
    logic [31:0] d;
    ack_en[3] = 1'b1;
    bus_write('hA0C, 32'h2);
    go();
    wait_idle("R5 code2 completes", 20);
    check("R2 code2 clk_en", 32'(mod_clk_en[3]), 32'h0);
    check("R2 code2 mod_rst", 32'(mod_rst[3]), 32'h0);
    check("R5 code2 used request", 32'(req_seen[3]), 32'h1);
    mod_state(3, d); check("R3 mod3 state 2", d & 32'h3, 32'h2);
  endtask

  // R9: acknowledge level visible in module status
  task automatic t_ack_level();
    logic [31:0] d;
    ack_hold[2] = 1'b1;
    repeat (5) @(negedge clk);
    mod_state(2, d);
    check("R9 ack bit high", (d >> 16) & 32'h1, 32'h1);
    check("R9 state field", d & 32'h3, 32'h1);
    ack_hold[2] = 1'b0;
    repeat (5) @(negedge clk);
    mod_state(2, d);
    check("R9 ack bit low", (d >> 16) & 32'h1, 32'h0);
  endtask

  // R5/R7/R8: module 0 never acknowledges
  task automatic t_hang_force();
    logic [31:0] d;
    bus_write('hA00, 32'h1);
    go();
    repeat (50) @(negedge clk);
    bus_read('h128, d);
    check("R5 busy stays without ack", d & 32'h1, 32'h1);
    check("R5 request stays", 32'(idle_req[0]), 32'h1);
    check("R5 reset not asserted", 32'(mod_rst[0]), 32'h0);
    bus_write('hA08, 32'h3);
    go();
    repeat (10) @(negedge clk);
    mod_state(2, d); check("R8 mod2 not moved", d & 32'h3, 32'h1);
    check("R8 mod2 reset unchanged", 32'(mod_rst[2]), 32'h1);
    bus_write('hA00, 32'h8000_0001);
    wait_idle("R7 force completes", 20);
    check("R7 mod0 reset asserted", 32'(mod_rst[0]), 32'h1);
    check("R7 mod0 clock on", 32'(mod_clk_en[0]), 32'h1);
    check("R10 mod0 request low", 32'(idle_req[0]), 32'h0);
    mod_state(0, d); check("R7 mod0 state 1", d & 32'h3, 32'h1);
    mod_state(2, d); check("R8 mod2 still 1", d & 32'h3, 32'h1);
    bus_write('hA00, 32'h1);
    go();
    wait_idle("R3 rerun completes", 20);
    mod_state(2, d); check("R3 mod2 moves on new go", d & 32'h3, 32'h3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_power_up();
    t_handshake();
    t_code2();
    t_ack_level();
    t_hang_force();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule